// File: doc/BRIEF.md
# Serial receive start controller

This block decides when a synchronous serial receiver starts and stops capturing words. It runs on the system clock and advances only on a one-cycle receive-clock strobe. The strobe is first qualified by a clock-gating choice that can depend on the frame-sync input. The qualified strobe drives every counter, edge detector and state change, and it is also an output, so the shifter beside the block steps on the same cycles.

A 32-bit configuration word holds several settings:
- which of nine events starts a reception: free running, a transmitter-start pulse, an RF level, an RF edge, or a compare-0 match;
- a start delay counted in qualified strobes;
- a stop mode, which turns compare-0 starts into a run that lasts until compare-1;
- a frame-sync period;
- the gating choice.

A write-protect input freezes the word. Clearing the receiver enable drops the block back to idle at once.

Top module: `rx_start_ctrl`

## Requirements
- R1: The configuration word resets to 0 and is read back on `cfg_q`. A `cfg_wr` cycle loads `cfg_wdata` into it. A write is ignored while `wp_en` is high. Field positions are: period [31:24], start delay [23:16], stop mode [12], start select [11:8], gating [7:6]. Bits [5:0] and [15:13] are stored only.
- R2: `rk_gated_en` is `rk_en` AND `rx_en` AND a gate term. The gate term depends on the gating field: code 1 passes it only while `rf_in` is 0, code 2 only while `rf_in` is 1, and codes 0 and 3 always pass it. Below, "strobe" means a cycle with `rk_gated_en` high.
- R3: With start select 0, every strobe that finds the block idle is a start event. Reception therefore restarts right after each end of word.
- R4: With select 1, a strobe carrying `tx_start` is a start event. With select 8, a strobe carrying `cmp0` is a start event.
- R5: With select 2, a strobe with `rf_in` = 0 is a start event. With select 3, a strobe with `rf_in` = 1 is a start event.
- R6: With select 4, a falling edge of RF starts a reception, and with select 5 a rising edge does. An edge is found by comparing `rf_in` with its value at the previous strobe. That stored value resets to 0.
- R7: Selects 6 and 7 both treat any RF change between strobes as a start event, giving exactly one start per change.
- R8: Start-select codes 9 to 15 never start a reception.
- R9: With delay D = 0, a start event makes `rx_active` and a one-cycle `start_pulse` rise on the next clock. With D > 0, the start happens at the D-th strobe after the event's strobe, with the same one-clock latency.
- R10: Start events are ignored while active or while the delay is counting.
- R11: A strobe carrying `eow` ends an active reception. The exception is select 8 with stop mode 1: there `eow` is ignored, and a strobe carrying `cmp1` ends the reception or cancels a pending delay.
- R12: With period P nonzero, `fsync_pulse` goes high for one clock after every 2×(P+1) strobes. With P = 0 it never goes high.
- R13: While `rx_en` is low, on the next clock the block is idle, the delay is cleared, the period count is 0, and no pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable |
| wp_en | input | 1 | Write protect for the configuration word |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| rk_en | input | 1 | Receive-clock enable strobe |
| rf_in | input | 1 | Sampled frame-sync line |
| tx_start | input | 1 | Transmitter-start pulse |
| cmp0 | input | 1 | Compare-0 match pulse |
| cmp1 | input | 1 | Compare-1 match pulse |
| eow | input | 1 | End-of-word pulse from the shifter |
| cfg_q | output | 32 | Configuration word readback |
| start_pulse | output | 1 | One-clock start-of-reception pulse |
| rx_active | output | 1 | Reception in progress |
| rk_gated_en | output | 1 | Qualified receive-clock enable |
| fsync_pulse | output | 1 | Periodic frame-sync pulse |

## Verification
The hardest case to reach is an exact count of starts from the change-driven modes. A stray start or a missed start only shows up if every RF change lands while the block is idle, with a strobe on both sides of the change. The bench reaches this by holding the strobe on every clock and keeping `eow` high, so each reception ends one strobe after it starts. It then toggles RF on a fixed spacing and counts the starts against the number of toggles. Randomised runs then mix gating, delay, compare-1 cancels during the delay, and enable drops, with a behavioural model checking every clock.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int CFG_W    = 32;
    localparam int PER_W    = 8;
    localparam int PER_LSB  = 24;
    localparam int DLY_W    = 8;
    localparam int DLY_LSB  = 16;
    localparam int STOP_BIT = 12;
    localparam int SEL_W    = 4;
    localparam int SEL_LSB  = 8;
    localparam int GATE_W   = 2;
    localparam int GATE_LSB = 6;
    localparam int PCNT_W   = PER_W + 1;

    typedef enum logic [SEL_W-1:0] {
        SRC_FREE    = 4'd0,
        SRC_TX      = 4'd1,
        SRC_RF_LO   = 4'd2,
        SRC_RF_HI   = 4'd3,
        SRC_RF_FALL = 4'd4,
        SRC_RF_RISE = 4'd5,
        SRC_RF_CHG  = 4'd6,
        SRC_RF_ANY  = 4'd7,
        SRC_CMP0    = 4'd8
    } src_e;

    typedef enum logic [GATE_W-1:0] {
        GATE_ALWAYS = 2'd0,
        GATE_RF_LO  = 2'd1,
        GATE_RF_HI  = 2'd2,
        GATE_SPARE  = 2'd3
    } gate_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } seq_e;

    typedef struct packed {
        logic [PER_W-1:0]  period;
        logic [DLY_W-1:0]  delay;
        logic              stop;
        logic [SEL_W-1:0]  sel;
        logic [GATE_W-1:0] gate;
    } fields_t;
endpackage

// File: rtl/rxs_cfg_reg.sv
module rxs_cfg_reg
    import rxs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             wp,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] word,
    output fields_t          fields
);
    typedef struct packed {
        logic [CFG_W-1:0] word;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr && !wp) begin
            st_d.word = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        word          = st_q.word;
        fields.period = st_q.word[PER_LSB +: PER_W];
        fields.delay  = st_q.word[DLY_LSB +: DLY_W];
        fields.stop   = st_q.word[STOP_BIT];
        fields.sel    = st_q.word[SEL_LSB +: SEL_W];
        fields.gate   = st_q.word[GATE_LSB +: GATE_W];
    end

    AST_WP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wp) |=> $stable(word)); // R1
endmodule

// File: rtl/rxs_trig.sv
module rxs_trig
    import rxs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rk_en,
    input  logic              rf,
    input  logic              tx_start,
    input  logic              cmp0,
    input  logic [SEL_W-1:0]  sel,
    input  logic [GATE_W-1:0] gate,
    output logic              strobe,
    output logic              trig
);
    typedef struct packed {
        logic rf_prev;
    } trig_st_t;

    trig_st_t st_d, st_q;
    logic     pass;
    logic     rf_changed;

    always_comb begin
        case (gate)
            GATE_RF_LO: pass = !rf;
            GATE_RF_HI: pass = rf;
            default:    pass = 1'b1;
        endcase
        strobe     = rk_en && en && pass;
        rf_changed = rf ^ st_q.rf_prev;

        case (sel)
            SRC_FREE:    trig = 1'b1;
            SRC_TX:      trig = tx_start;
            SRC_RF_LO:   trig = !rf;
            SRC_RF_HI:   trig = rf;
            SRC_RF_FALL: trig = st_q.rf_prev && !rf;
            SRC_RF_RISE: trig = !st_q.rf_prev && rf;
            SRC_RF_CHG:  trig = rf_changed;
            SRC_RF_ANY:  trig = rf_changed;
            SRC_CMP0:    trig = cmp0;
            default:     trig = 1'b0;
        endcase

        st_d = st_q;
        if (strobe) begin
            st_d.rf_prev = rf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_RF_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(st_q.rf_prev)); // R6
endmodule

// File: rtl/rxs_seq.sv
module rxs_seq
    import rxs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             strobe,
    input  logic             trig,
    input  logic             eow,
    input  logic             cmp1,
    input  logic [SEL_W-1:0] sel,
    input  logic             stop,
    input  logic [DLY_W-1:0] delay,
    output logic             start_pulse,
    output logic             active
);
    typedef struct packed {
        seq_e             state;
        logic [DLY_W-1:0] cnt;
        logic             start;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    hold_mode;
    logic    end_ev;

    always_comb begin
        hold_mode = (sel == SRC_CMP0) && stop;
        end_ev    = hold_mode ? cmp1 : eow;

        st_d       = st_q;
        st_d.start = 1'b0;

        if (!en) begin
            st_d.state = ST_IDLE;
            st_d.cnt   = '0;
        end else if (strobe) begin
            case (st_q.state)
                ST_IDLE: begin
                    if (trig) begin
                        if (delay == '0) begin
                            st_d.state = ST_RUN;
                            st_d.start = 1'b1;
                        end else begin
                            st_d.state = ST_WAIT;
                            st_d.cnt   = delay;
                        end
                    end
                end
                ST_WAIT: begin
                    if (hold_mode && cmp1) begin
                        st_d.state = ST_IDLE;
                        st_d.cnt   = '0;
                    end else if (st_q.cnt <= 1) begin
                        st_d.state = ST_RUN;
                        st_d.start = 1'b1;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                ST_RUN: begin
                    if (end_ev) begin
                        st_d.state = ST_IDLE;
                    end
                end
                default: begin
                    st_d.state = ST_IDLE;
                    st_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, cnt: '0, start: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign start_pulse = st_q.start;
    assign active      = (st_q.state == ST_RUN);

    AST_START_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> active); // R9
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.state == ST_IDLE && st_q.cnt == '0 && !start_pulse)); // R13
    AST_UNUSED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.state == ST_IDLE && sel > 4'd8) |=> st_q.state == ST_IDLE); // R8
    AST_HOLD_EOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en && active && hold_mode && strobe && eow && !cmp1) |=> active); // R11
endmodule

// File: rtl/rxs_period.sv
module rxs_period
    import rxs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             strobe,
    input  logic [PER_W-1:0] period,
    output logic             fsync
);
    typedef struct packed {
        logic [PCNT_W-1:0] cnt;
        logic              pulse;
    } per_st_t;

    per_st_t           st_d, st_q;
    logic [PCNT_W-1:0] last;

    always_comb begin
        last       = {period, 1'b1};
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!en || period == '0) begin
            st_d.cnt = '0;
        end else if (strobe) begin
            if (st_q.cnt >= last) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fsync = st_q.pulse;

    AST_NO_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0) |=> !fsync); // R12
    AST_OFF_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!fsync && st_q.cnt == '0)); // R13
endmodule

// File: rtl/rx_start_ctrl.sv
module rx_start_ctrl
    import rxs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             wp_en,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             rk_en,
    input  logic             rf_in,
    input  logic             tx_start,
    input  logic             cmp0,
    input  logic             cmp1,
    input  logic             eow,
    output logic [CFG_W-1:0] cfg_q,
    output logic             start_pulse,
    output logic             rx_active,
    output logic             rk_gated_en,
    output logic             fsync_pulse
);
    fields_t f;
    logic    strobe;
    logic    trig;

    rxs_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .wp     (wp_en),
        .wdata  (cfg_wdata),
        .word   (cfg_q),
        .fields (f)
    );

    rxs_trig u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (rx_en),
        .rk_en    (rk_en),
        .rf       (rf_in),
        .tx_start (tx_start),
        .cmp0     (cmp0),
        .sel      (f.sel),
        .gate     (f.gate),
        .strobe   (strobe),
        .trig     (trig)
    );

    rxs_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (rx_en),
        .strobe      (strobe),
        .trig        (trig),
        .eow         (eow),
        .cmp1        (cmp1),
        .sel         (f.sel),
        .stop        (f.stop),
        .delay       (f.delay),
        .start_pulse (start_pulse),
        .active      (rx_active)
    );

    rxs_period u_per (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (rx_en),
        .strobe (strobe),
        .period (f.period),
        .fsync  (fsync_pulse)
    );

    assign rk_gated_en = strobe;
endmodule

// File: tb/rx_start_ctrl_tb.sv
`timescale 1ns/1ps
module rx_start_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0, wp_en = 1'b0, cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        rk_en = 1'b0, rf_in = 1'b0, tx_start = 1'b0;
    logic        cmp0 = 1'b0, cmp1 = 1'b0, eow = 1'b0;
    logic [31:0] cfg_q;
    logic        start_pulse, rx_active, rk_gated_en, fsync_pulse;

    int checks = 0, fails = 0, n_starts = 0;
    string phase = "R1 reset";

    // behavioural model state
    logic [31:0] m_cfg = '0;
    int          m_state = 0;   // 0 idle, 1 counting delay, 2 receiving
    int          m_cnt = 0, m_pcnt = 0;
    bit          m_start = 0, m_fs = 0, m_rfp = 0;

    always #2.5 clk = ~clk;

    rx_start_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .wp_en(wp_en), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .rk_en(rk_en), .rf_in(rf_in), .tx_start(tx_start),
        .cmp0(cmp0), .cmp1(cmp1), .eow(eow), .cfg_q(cfg_q), .start_pulse(start_pulse),
        .rx_active(rx_active), .rk_gated_en(rk_gated_en), .fsync_pulse(fsync_pulse)
    );

    function automatic bit gate_ok(input logic [1:0] code, input logic rf);
        if (code == 2'd1) return !rf;
        if (code == 2'd2) return rf;
        return 1'b1;
    endfunction

    function automatic bit trig_of(input int sel, input bit rf, input bit prev,
                                   input bit tx, input bit c0);
        case (sel)
            0: return 1;
            1: return tx;
            2: return !rf;
            3: return rf;
            4: return prev && !rf;
            5: return !prev && rf;
            6, 7: return rf != prev;
            8: return c0;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] mk(input int per, input int dly, input int stp,
                                       input int sel, input int gate);
        mk = '0;
        mk[31:24] = per[7:0];
        mk[23:16] = dly[7:0];
        mk[12]    = stp[0];
        mk[11:8]  = sel[3:0];
        mk[7:6]   = gate[1:0];
    endfunction

    always @(posedge clk) begin : model
        bit g, t, hold;
        int per, dly, sel;
        if (!rst_n) begin
            m_cfg = '0; m_state = 0; m_cnt = 0; m_pcnt = 0;
            m_start = 0; m_fs = 0; m_rfp = 0;
        end else begin
            sel  = int'(m_cfg[11:8]);
            dly  = int'(m_cfg[23:16]);
            per  = int'(m_cfg[31:24]);
            g    = rk_en && rx_en && gate_ok(m_cfg[7:6], rf_in);
            t    = trig_of(sel, rf_in, m_rfp, tx_start, cmp0);
            hold = (sel == 8) && m_cfg[12];
            m_start = 0;
            if (!rx_en) begin
                m_state = 0; m_cnt = 0;
            end else if (g) begin
                if (m_state == 0) begin
                    if (t) begin
                        if (dly == 0) begin m_state = 2; m_start = 1; end
                        else begin m_state = 1; m_cnt = dly; end
                    end
                end else if (m_state == 1) begin
                    if (hold && cmp1) begin m_state = 0; m_cnt = 0; end
                    else begin
                        m_cnt--;
                        if (m_cnt == 0) begin m_state = 2; m_start = 1; end
                    end
                end else begin
                    if (hold ? cmp1 : eow) m_state = 0;
                end
            end
            m_fs = 0;
            if (!rx_en || per == 0) m_pcnt = 0;
            else if (g) begin
                m_pcnt++;
                if (m_pcnt >= 2 * (per + 1)) begin m_pcnt = 0; m_fs = 1; end
            end
            if (g) m_rfp = rf_in;
            if (cfg_wr && !wp_en) m_cfg = cfg_wdata;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", phase, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin : compare
        #1;
        chk("cfg_q (R1)", cfg_q, m_cfg);
        chk("start_pulse", {31'b0, start_pulse}, {31'b0, m_start});
        chk("rx_active", {31'b0, rx_active}, {31'b0, m_state == 2});
        chk("fsync_pulse", {31'b0, fsync_pulse}, {31'b0, m_fs});
        chk("rk_gated_en (R2)", {31'b0, rk_gated_en},
            {31'b0, rk_en && rx_en && gate_ok(m_cfg[7:6], rf_in)});
        if (start_pulse === 1'b1) n_starts++;
    end

    task automatic quiet();
        tx_start = 0; cmp0 = 0; cmp1 = 0; eow = 0; cfg_wr = 0;
    endtask

    task automatic setcfg(input logic [31:0] v);
        @(negedge clk);
        quiet();
        cfg_wr = 1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic run(input int n, input int p_rk, input int p_rf, input int p_tx,
                       input int p_c0, input int p_c1, input int p_eow);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rk_en    = (int'($urandom_range(99)) < p_rk);
            if (int'($urandom_range(99)) < p_rf) rf_in = ~rf_in;
            tx_start = (int'($urandom_range(99)) < p_tx);
            cmp0     = (int'($urandom_range(99)) < p_c0);
            cmp1     = (int'($urandom_range(99)) < p_c1);
            eow      = (int'($urandom_range(99)) < p_eow);
        end
        @(negedge clk);
        quiet();
    endtask

    task automatic count_changes(input int sel);
        setcfg(mk(0, 0, 0, sel, 0));
        rx_en = 1; rk_en = 1; eow = 1;
        repeat (4) @(negedge clk);
        n_starts = 0;
        for (int k = 0; k < 6; k++) begin
            rf_in = ~rf_in;
            repeat (4) @(negedge clk);
        end
        chk("starts per RF change (R7)", n_starts, 6);
        eow = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1;

        phase = "R1 write protect";
        wp_en = 1;
        setcfg(32'hA5C3_F1E7);
        wp_en = 0;
        setcfg(32'h5A3C_1E18);
        setcfg(32'h0000_0000);

        phase = "R2 clock gating";
        rx_en = 1;
        for (int gc = 0; gc < 4; gc++) begin
            setcfg(mk(0, 0, 0, 15, gc));
            run(40, 70, 40, 0, 0, 0, 0);
        end

        phase = "R3 free running";
        setcfg(mk(0, 0, 0, 0, 0));
        run(80, 60, 20, 0, 0, 0, 30);

        phase = "R4 transmitter start";
        setcfg(mk(0, 0, 0, 1, 0));
        run(80, 70, 20, 20, 0, 0, 25);
        phase = "R4 compare-0 start";
        setcfg(mk(0, 0, 0, 8, 0));
        run(80, 70, 20, 0, 20, 10, 25);

        phase = "R5 RF level";
        setcfg(mk(0, 0, 0, 2, 0));
        run(60, 70, 25, 0, 0, 0, 40);
        setcfg(mk(0, 0, 0, 3, 1));
        run(60, 70, 25, 0, 0, 0, 40);

        phase = "R6 RF edge";
        setcfg(mk(0, 0, 0, 4, 0));
        run(80, 60, 35, 0, 0, 0, 50);
        setcfg(mk(0, 0, 0, 5, 2));
        run(80, 60, 35, 0, 0, 0, 50);

        phase = "R7 any RF change";
        count_changes(6);
        count_changes(7);
        setcfg(mk(0, 0, 0, 7, 0));
        run(80, 60, 35, 0, 0, 0, 50);

        phase = "R8 unused select";
        @(negedge clk); rx_en = 0;
        @(negedge clk); rx_en = 1;
        for (int s = 9; s < 16; s++) begin
            setcfg(mk(0, 0, 0, s, 0));
            n_starts = 0;
            run(30, 80, 30, 30, 30, 10, 30);
            chk("starts with unused select (R8)", n_starts, 0);
        end

        phase = "R9 start delay";
        setcfg(mk(0, 3, 0, 1, 0));
        run(120, 60, 20, 15, 0, 0, 20);
        setcfg(mk(0, 1, 0, 3, 0));
        run(80, 60, 30, 0, 0, 0, 20);

        phase = "R10 busy ignores triggers";
        setcfg(mk(0, 5, 0, 1, 0));
        run(150, 80, 0, 60, 0, 0, 8);

        phase = "R11 stop on compare-1";
        setcfg(mk(0, 2, 1, 8, 0));
        run(200, 70, 20, 0, 15, 8, 40);
        phase = "R11 stop after word";
        setcfg(mk(0, 0, 0, 8, 0));
        run(100, 70, 20, 0, 15, 15, 20);

        phase = "R12 frame sync period";
        setcfg(mk(0, 0, 0, 15, 0));
        run(60, 80, 20, 0, 0, 0, 0);
        setcfg(mk(1, 0, 0, 15, 0));
        run(60, 100, 0, 0, 0, 0, 0);
        setcfg(mk(3, 0, 0, 15, 0));
        run(120, 60, 20, 0, 0, 0, 0);

        phase = "R13 enable drop";
        setcfg(mk(2, 4, 0, 1, 0));
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            rx_en    = ($urandom_range(99) < 85);
            rk_en    = ($urandom_range(99) < 70);
            tx_start = ($urandom_range(99) < 25);
            eow      = ($urandom_range(99) < 15);
        end
        @(negedge clk);
        quiet(); rx_en = 1;
        repeat (4) @(negedge clk);

        summary();
        $finish;
    end
endmodule